// File: doc/BRIEF.md
# Flash Device Reset Sequencer

This block sequences every reset a NAND-style flash device with an on-chip buffer RAM can receive, and runs the boot-code load that follows power-up. There are four kinds of reset, and each affects a different set of state. A cold reset comes from the digital power-on release input and clears everything. A warm reset comes from the active-low external reset pin. A hot reset comes from a host request, either as a command or as a register write. A core-only reset is a separate command that stops only the flash core. In response, the block drives a one-cycle abort pulse to the core, a one-cycle register-initialise pulse, a level that holds outputs at their defaults, and a ready flag.

After the power-on release, the sequencer waits a fixed time. It then copies the first 1 KB of the array into the boot area of the buffer RAM. Each word takes one request/response read from the array and one valid/ready write into the RAM. Every delay is a counter derived from the clock frequency parameter. The block also keeps a flag that records whether a program or erase was cut short, so the host can see that the cells being altered now hold invalid data. It gates the interrupt output with an enable bit that only the host can set.

Controller states: `ST_POR_WAIT` (timing the start-up delay), `ST_COPY` (boot copy running), `ST_RESET` (one-cycle internal reset), `ST_HOLD` (pin still held low), `ST_IDLE` (normal operation), `ST_CORE` (one-cycle core-only abort). Transitions: POR_WAIT→COPY on timer expiry; COPY→IDLE on the last accepted write; POR_WAIT/COPY/IDLE/CORE→RESET on a qualified pin or a host reset; RESET→HOLD while the pin stays low, otherwise RESET→IDLE; HOLD→IDLE on pin release; IDLE→CORE on a core-only command; CORE→IDLE. The copier has its own states: `CP_IDLE`, `CP_REQ` (read request), `CP_RSP` (waiting for data), `CP_WR` (RAM write).

Top module: `flash_reset_seq`

## Requirements
- R1: While `por_n` is low, `ready`, `arr_rd_valid`, `bram_wr_valid`, `int_out`, `core_abort` and `reg_init` are 0 and `out_default` is 1. A low `por_n` overrides every other input.
- R2: The first array read request (`arr_rd_valid` = 1) appears exactly CLK_MHZ*BOOT_WAIT_US rising clock edges after `por_n` rises, and not one edge earlier.
- R3: The copy moves BOOT_BYTES/(DATA_W/8) words, in increasing word address from 0. Each RAM write uses the same address as its array read and carries the data returned for that read. A transfer completes only on a cycle with valid and ready both high.
- R4: `ready` rises only after the final RAM write is accepted, and stays 0 throughout the copy.
- R5: The pin must be seen low for at least ceil(CLK_MHZ*PIN_MIN_NS/1000) consecutive sampled cycles. Such a pulse produces exactly one `reg_init` pulse and one `core_abort` pulse, and a shorter pulse produces neither. `out_default` stays 1 while a qualified pin remains low.
- R6: A one-cycle `hot_cmd` or `hot_reg_wr` produces exactly one `reg_init` pulse and one `core_abort` pulse, and clears the interrupt enable. `ready` returns afterwards if the boot copy had completed.
- R7: No array read or RAM write is issued during a warm or hot reset. A warm or hot reset during the start-up wait or the copy cancels the load for good, and `ready` stays 0 until the next power-on.
- R8: A core-only command in normal operation produces exactly one `core_abort` pulse and no `reg_init`. `out_default` stays 0, `ready` stays 1, the interrupt enable is kept, and no RAM access occurs.
- R9: `cells_invalid` becomes 1 when any abort is taken while `core_busy` is 1. It holds until `op_start`, and it is not set by an abort taken while `core_busy` is 0.
- R10: `int_out` equals the interrupt enable ANDed with `int_req`. The enable is 0 after power-on and changes only on a host write (`ioe_wr`, value `ioe_wdata`).
- R11: When a hot reset and a core-only command arrive in the same cycle, only the hot reset takes effect: one `reg_init` pulse and one `core_abort` pulse in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on release, active low, asynchronous assert |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous to clk |
| hot_cmd | input | 1 | Host reset request given as a command |
| hot_reg_wr | input | 1 | Host reset request given as a register write |
| core_rst_cmd | input | 1 | Core-only reset command |
| core_busy | input | 1 | Core program or erase in progress |
| op_start | input | 1 | A new core operation starts |
| ioe_wr | input | 1 | Host write strobe for the interrupt enable |
| ioe_wdata | input | 1 | Interrupt enable value written by the host |
| int_req | input | 1 | Internal interrupt source |
| arr_rd_valid | output | 1 | Array read request valid |
| arr_rd_addr | output | AW | Array word address |
| arr_rd_ready | input | 1 | Array accepts the read request |
| arr_rsp_valid | input | 1 | Array read data valid |
| arr_rsp_data | input | DATA_W | Array read data |
| bram_wr_valid | output | 1 | Boot RAM write valid |
| bram_wr_addr | output | AW | Boot RAM word address |
| bram_wr_data | output | DATA_W | Boot RAM write data |
| bram_wr_ready | input | 1 | Boot RAM accepts the write |
| core_abort | output | 1 | One-cycle abort to the flash core |
| reg_init | output | 1 | One-cycle register initialise |
| out_default | output | 1 | Hold outputs at default values |
| ready | output | 1 | Boot code loaded and device in normal operation |
| cells_invalid | output | 1 | A program or erase was cut short |
| int_out | output | 1 | Gated interrupt output |

## Verification
The hardest situation to reach is a reset that lands in the middle of the boot copy, while a RAM write is stalled on its ready. The bench gets there by choosing the RAM and array ready patterns itself. It counts accepted writes and fires a host reset once a chosen number have landed. It then watches that no further request appears over a long window. The pin qualifier boundary is found by sweeping the low time across the threshold one cycle at a time, and the copy is repeated under several stall patterns.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
    typedef enum logic [2:0] {
        ST_POR_WAIT,
        ST_COPY,
        ST_RESET,
        ST_HOLD,
        ST_IDLE,
        ST_CORE
    } seq_state_t;

    typedef enum logic [1:0] {
        CP_IDLE,
        CP_REQ,
        CP_RSP,
        CP_WR
    } copy_state_t;
endpackage

// File: rtl/rstseq_pin_filter.sv
module rstseq_pin_filter #(
    parameter int MIN_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic qual_pulse,
    output logic held_low
);
    localparam int CW = $clog2(MIN_CYC + 1);

    logic          sync1, sync2;
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= pin_n;
            sync2 <= sync1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (sync2)
            low_cnt <= '0;
        else if (low_cnt != CW'(MIN_CYC))
            low_cnt <= low_cnt + 1'b1;
    end

    // Fires once per low period, on the cycle the low time reaches the threshold.
    assign qual_pulse = !sync2 && (low_cnt == CW'(MIN_CYC - 1));
    assign held_low   = !sync2 && (low_cnt == CW'(MIN_CYC));
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
    parameter int CYCLES = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    assign expire = run && (cnt == CW'(CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (run && !expire)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rstseq_boot_copy.sv
module rstseq_boot_copy
    import rstseq_pkg::*;
#(
    parameter int WORDS  = 512,
    parameter int DATA_W = 16,
    parameter int AW     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    output logic              rd_valid,
    output logic [AW-1:0]     rd_addr,
    input  logic              rd_ready,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              wr_valid,
    output logic [AW-1:0]     wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ready,
    output logic              done
);
    copy_state_t       cs, cs_n;
    logic [AW-1:0]     idx;
    logic [DATA_W-1:0] word_q;
    logic              last;

    assign last = (idx == AW'(WORDS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cs <= CP_IDLE;
        else if (abort)
            cs <= CP_IDLE;
        else
            cs <= cs_n;
    end

    always_comb begin
        cs_n = cs;
        unique case (cs)
            CP_IDLE: if (start)     cs_n = CP_REQ;
            CP_REQ:  if (rd_ready)  cs_n = CP_RSP;
            CP_RSP:  if (rsp_valid) cs_n = CP_WR;
            CP_WR:   if (wr_ready)  cs_n = last ? CP_IDLE : CP_REQ;
            default:                cs_n = CP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx    <= '0;
            word_q <= '0;
        end else begin
            if (cs == CP_IDLE && start)
                idx <= '0;
            if (cs == CP_RSP && rsp_valid)
                word_q <= rsp_data;
            if (cs == CP_WR && wr_ready && !last)
                idx <= idx + 1'b1;
        end
    end

    always_comb begin
        rd_valid = (cs == CP_REQ);
        wr_valid = (cs == CP_WR);
        rd_addr  = idx;
        wr_addr  = idx;
        wr_data  = word_q;
        done     = (cs == CP_WR) && wr_ready && last;
    end
endmodule

// File: rtl/flash_reset_seq.sv
module flash_reset_seq
    import rstseq_pkg::*;
#(
    parameter int CLK_MHZ      = 50,
    parameter int PIN_MIN_NS   = 200,
    parameter int BOOT_WAIT_US = 400,
    parameter int BOOT_BYTES   = 1024,
    parameter int DATA_W       = 16,
    localparam int PIN_MIN_CYC = (CLK_MHZ * PIN_MIN_NS + 999) / 1000,
    localparam int WAIT_CYC    = CLK_MHZ * BOOT_WAIT_US,
    localparam int WORDS       = BOOT_BYTES / (DATA_W / 8),
    localparam int AW          = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_pin_n,
    input  logic              hot_cmd,
    input  logic              hot_reg_wr,
    input  logic              core_rst_cmd,
    input  logic              core_busy,
    input  logic              op_start,
    input  logic              ioe_wr,
    input  logic              ioe_wdata,
    input  logic              int_req,
    output logic              arr_rd_valid,
    output logic [AW-1:0]     arr_rd_addr,
    input  logic              arr_rd_ready,
    input  logic              arr_rsp_valid,
    input  logic [DATA_W-1:0] arr_rsp_data,
    output logic              bram_wr_valid,
    output logic [AW-1:0]     bram_wr_addr,
    output logic [DATA_W-1:0] bram_wr_data,
    input  logic              bram_wr_ready,
    output logic              core_abort,
    output logic              reg_init,
    output logic              out_default,
    output logic              ready,
    output logic              cells_invalid,
    output logic              int_out
);
    seq_state_t state, state_n;

    logic warm_trig, pin_held, tmr_exp, copy_done;
    logic hot_req, rst_req, take_rst, take_core;
    logic copy_start, copy_abort;
    logic boot_ok, ioe_q, abort_q;

    rstseq_pin_filter #(.MIN_CYC(PIN_MIN_CYC)) u_pin (
        .clk        (clk),
        .rst_n      (por_n),
        .pin_n      (rst_pin_n),
        .qual_pulse (warm_trig),
        .held_low   (pin_held)
    );

    rstseq_timer #(.CYCLES(WAIT_CYC)) u_wait (
        .clk    (clk),
        .rst_n  (por_n),
        .run    (state == ST_POR_WAIT),
        .expire (tmr_exp)
    );

    rstseq_boot_copy #(.WORDS(WORDS), .DATA_W(DATA_W), .AW(AW)) u_copy (
        .clk       (clk),
        .rst_n     (por_n),
        .start     (copy_start),
        .abort     (copy_abort),
        .rd_valid  (arr_rd_valid),
        .rd_addr   (arr_rd_addr),
        .rd_ready  (arr_rd_ready),
        .rsp_valid (arr_rsp_valid),
        .rsp_data  (arr_rsp_data),
        .wr_valid  (bram_wr_valid),
        .wr_addr   (bram_wr_addr),
        .wr_data   (bram_wr_data),
        .wr_ready  (bram_wr_ready),
        .done      (copy_done)
    );

    assign hot_req    = hot_cmd || hot_reg_wr;
    assign rst_req    = warm_trig || hot_req;
    assign take_rst   = rst_req && (state inside {ST_POR_WAIT, ST_COPY, ST_IDLE, ST_CORE});
    assign take_core  = (state == ST_IDLE) && !rst_req && core_rst_cmd;
    assign copy_start = (state == ST_POR_WAIT) && tmr_exp && !rst_req;
    assign copy_abort = (state == ST_COPY) && rst_req;

    // Next-state decode
    always_comb begin
        state_n = state;
        unique case (state)
            ST_POR_WAIT: if (rst_req) state_n = ST_RESET;
                         else if (tmr_exp) state_n = ST_COPY;
            ST_COPY:     if (rst_req) state_n = ST_RESET;
                         else if (copy_done) state_n = ST_IDLE;
            ST_RESET:    state_n = pin_held ? ST_HOLD : ST_IDLE;
            ST_HOLD:     state_n = pin_held ? ST_HOLD : ST_IDLE;
            ST_IDLE:     if (rst_req) state_n = ST_RESET;
                         else if (core_rst_cmd) state_n = ST_CORE;
            ST_CORE:     state_n = rst_req ? ST_RESET : ST_IDLE;
            default:     state_n = ST_IDLE;
        endcase
    end

    // State register and the few registers it owns
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state   <= ST_POR_WAIT;
            boot_ok <= 1'b0;
            ioe_q   <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            state <= state_n;
            if (state == ST_COPY && copy_done && !rst_req)
                boot_ok <= 1'b1;
            if (state == ST_RESET)
                ioe_q <= 1'b0;
            else if (ioe_wr)
                ioe_q <= ioe_wdata;
            if ((take_rst || take_core) && core_busy)
                abort_q <= 1'b1;
            else if (op_start)
                abort_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        core_abort    = (state == ST_RESET) || (state == ST_CORE);
        reg_init      = (state == ST_RESET);
        out_default   = !((state == ST_IDLE) || (state == ST_CORE));
        ready         = boot_ok && !out_default;
        cells_invalid = abort_q;
        int_out       = ioe_q && int_req;
    end
endmodule

// File: rtl/rstseq_checker.sv
module rstseq_checker
    import rstseq_pkg::*;
#(
    parameter int AW     = 9,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              por_n,
    input seq_state_t        state,
    input logic              rst_pin_n,
    input logic              hot_cmd,
    input logic              hot_reg_wr,
    input logic              core_rst_cmd,
    input logic              core_busy,
    input logic              int_req,
    input logic              arr_rd_valid,
    input logic              bram_wr_valid,
    input logic              bram_wr_ready,
    input logic [AW-1:0]     bram_wr_addr,
    input logic [DATA_W-1:0] bram_wr_data,
    input logic              core_abort,
    input logic              reg_init,
    input logic              out_default,
    input logic              ready,
    input logic              cells_invalid,
    input logic              int_out
);
    assert_ram_quiet_R7: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_RESET || state == ST_HOLD) |-> (!arr_rd_valid && !bram_wr_valid));

    assert_ready_after_copy_R4: assert property (@(posedge clk) disable iff (!por_n)
        $rose(ready) |-> ($past(bram_wr_valid && bram_wr_ready)
                          || $past(state == ST_RESET) || $past(state == ST_HOLD)));

    assert_wr_hold_R3: assert property (@(posedge clk) disable iff (!por_n)
        (bram_wr_valid && !bram_wr_ready) |=>
            ((bram_wr_valid && $stable(bram_wr_addr) && $stable(bram_wr_data))
             || state == ST_RESET));

    assert_init_cause_R6: assert property (@(posedge clk) disable iff (!por_n)
        $rose(reg_init) |-> ($past(hot_cmd || hot_reg_wr) || !$past(rst_pin_n, 3)));

    assert_core_only_R8: assert property (@(posedge clk) disable iff (!por_n)
        (core_abort && !reg_init) |-> (!out_default && $past(core_rst_cmd)));

    assert_flag_cause_R9: assert property (@(posedge clk) disable iff (!por_n)
        $rose(cells_invalid) |-> $past(core_busy));

    assert_int_gate_R10: assert property (@(posedge clk) disable iff (!por_n)
        int_out |-> int_req);
endmodule

bind flash_reset_seq rstseq_checker #(.AW(AW), .DATA_W(DATA_W)) u_rstseq_chk (
    .clk           (clk),
    .por_n         (por_n),
    .state         (state),
    .rst_pin_n     (rst_pin_n),
    .hot_cmd       (hot_cmd),
    .hot_reg_wr    (hot_reg_wr),
    .core_rst_cmd  (core_rst_cmd),
    .core_busy     (core_busy),
    .int_req       (int_req),
    .arr_rd_valid  (arr_rd_valid),
    .bram_wr_valid (bram_wr_valid),
    .bram_wr_ready (bram_wr_ready),
    .bram_wr_addr  (bram_wr_addr),
    .bram_wr_data  (bram_wr_data),
    .core_abort    (core_abort),
    .reg_init      (reg_init),
    .out_default   (out_default),
    .ready         (ready),
    .cells_invalid (cells_invalid),
    .int_out       (int_out)
);

// File: tb/tb_flash_reset_seq.sv
module tb_flash_reset_seq;
    localparam int CLK_P   = 10;
    localparam int MHZ     = 1;
    localparam int PIN_NS  = 4000;
    localparam int WAIT_US = 30;
    localparam int BYTES   = 16;
    localparam int DW      = 16;
    localparam int PIN_MIN = (MHZ * PIN_NS + 999) / 1000;
    localparam int WAIT    = MHZ * WAIT_US;
    localparam int WORDS   = BYTES / (DW / 8);
    localparam int AW      = $clog2(WORDS);

    logic clk = 1'b0;
    logic por_n = 1'b0, rst_pin_n = 1'b1, hot_cmd = 1'b0, hot_reg_wr = 1'b0;
    logic core_rst_cmd = 1'b0, core_busy = 1'b0, op_start = 1'b0;
    logic ioe_wr = 1'b0, ioe_wdata = 1'b0, int_req = 1'b0;
    logic arr_rd_ready = 1'b0, arr_rsp_valid = 1'b0, bram_wr_ready = 1'b0;
    logic [DW-1:0] arr_rsp_data = '0;
    logic arr_rd_valid, bram_wr_valid, core_abort, reg_init, out_default;
    logic ready, cells_invalid, int_out;
    logic [AW-1:0] arr_rd_addr, bram_wr_addr;
    logic [DW-1:0] bram_wr_data;

    always #(CLK_P / 2) clk = ~clk;

    flash_reset_seq #(.CLK_MHZ(MHZ), .PIN_MIN_NS(PIN_NS), .BOOT_WAIT_US(WAIT_US),
                      .BOOT_BYTES(BYTES), .DATA_W(DW)) dut (.*);

    int total = 0, fails = 0;
    int stall = 0, cyc = 0, wr_cnt = 0, rd_seen = 0, n_init = 0, n_abort = 0;
    logic          rsp_pend = 1'b0;
    logic [AW-1:0] pend_addr = '0;

    function automatic logic [DW-1:0] pat(int a);
        return DW'((a * 4951) ^ 16'hA5C3);
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    // Array and RAM responder plus pulse monitor, acting on falling edges
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            n_init  += int'(reg_init);
            n_abort += int'(core_abort);
            if (!por_n) begin
                rsp_pend = 1'b0;
                arr_rsp_valid = 1'b0;
                arr_rd_ready = 1'b0;
                bram_wr_ready = 1'b0;
            end else begin
                arr_rsp_valid = 1'b0;
                if (rsp_pend) begin
                    arr_rsp_valid = 1'b1;
                    arr_rsp_data  = pat(int'(pend_addr));
                    rsp_pend      = 1'b0;
                end
                arr_rd_ready  = (stall == 0) || (cyc % (stall + 1) == 0);
                bram_wr_ready = (stall == 0) || (cyc % (stall + 2) == 1);
                if (arr_rd_valid) rd_seen++;
                if (arr_rd_valid && arr_rd_ready) begin
                    rsp_pend  = 1'b1;
                    pend_addr = arr_rd_addr;
                end
                if (bram_wr_valid && bram_wr_ready) begin
                    chk("R3 write order", int'(bram_wr_addr), wr_cnt);
                    chk("R3 write data", int'(bram_wr_data), int'(pat(int'(bram_wr_addr))));
                    wr_cnt++;
                end
            end
        end
    end

    initial begin
        #(CLK_P * 150000);
        fails++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    task automatic cold_boot(int s);
        por_n = 1'b0;
        stall = s;
        repeat (2) tick();
        wr_cnt = 0;
        rd_seen = 0;
        por_n = 1'b1;
    endtask

    task automatic pulse_hot(bit by_reg);
        if (by_reg) hot_reg_wr = 1'b1; else hot_cmd = 1'b1;
        tick();
        hot_reg_wr = 1'b0;
        hot_cmd = 1'b0;
    endtask

    initial begin
        int d_i, d_a, w0;
        int_req = 1'b1;
        repeat (3) tick();
        // R1 / R11: everything quiet while power-on is held, even with other requests
        hot_cmd = 1'b1;
        core_rst_cmd = 1'b1;
        rst_pin_n = 1'b0;
        repeat (PIN_MIN + 3) tick();
        chk("R1 ready", int'(ready), 0);
        chk("R1 out_default", int'(out_default), 1);
        chk("R1 rd_valid", int'(arr_rd_valid), 0);
        chk("R1 wr_valid", int'(bram_wr_valid), 0);
        chk("R1 reg_init", n_init, 0);
        chk("R10 int_out before enable", int'(int_out), 0);
        hot_cmd = 1'b0;
        core_rst_cmd = 1'b0;
        rst_pin_n = 1'b1;

        // R2 / R3 / R4: cold boot under several stall patterns
        for (int s = 0; s < 4; s++) begin
            cold_boot(s);
            repeat (WAIT - 1) tick();
            chk("R2 no request before wait", int'(arr_rd_valid), 0);
            chk("R4 ready low in wait", int'(ready), 0);
            tick();
            chk("R2 request at wait end", int'(arr_rd_valid), 1);
            chk("R2 first address", int'(arr_rd_addr), 0);
            for (int k = 0; k < 400 && !ready; k++) begin
                if (!ready) chk("R4 ready low during copy", int'(wr_cnt == WORDS && out_default == 1'b0), 0);
                tick();
            end
            chk("R4 ready after copy", int'(ready), 1);
            chk("R3 word count", wr_cnt, WORDS);
            w0 = rd_seen;
            repeat (10) tick();
            chk("R3 no extra reads", rd_seen, w0);
        end

        // R10: interrupt enable gating
        chk("R10 int_out disabled", int'(int_out), 0);
        ioe_wr = 1'b1; ioe_wdata = 1'b1;
        tick();
        ioe_wr = 1'b0;
        chk("R10 int_out enabled", int'(int_out), 1);
        int_req = 1'b0;
        tick();
        chk("R10 int_out follows req", int'(int_out), 0);
        int_req = 1'b1;
        tick();

        // R8 / R9: core-only reset with an operation in progress
        d_i = n_init; d_a = n_abort; w0 = wr_cnt;
        core_busy = 1'b1;
        core_rst_cmd = 1'b1;
        tick();
        core_rst_cmd = 1'b0;
        core_busy = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R8 out_default low", int'(out_default), 0);
            chk("R8 ready kept", int'(ready), 1);
            tick();
        end
        chk("R8 one core abort", n_abort - d_a, 1);
        chk("R8 no reg init", n_init - d_i, 0);
        chk("R8 enable kept", int'(int_out), 1);
        chk("R8 no RAM write", wr_cnt, w0);
        chk("R9 flag set", int'(cells_invalid), 1);
        tick();
        chk("R9 flag held", int'(cells_invalid), 1);
        op_start = 1'b1;
        tick();
        op_start = 1'b0;
        chk("R9 flag cleared", int'(cells_invalid), 0);
        core_rst_cmd = 1'b1;
        tick();
        core_rst_cmd = 1'b0;
        repeat (2) tick();
        chk("R9 idle abort leaves flag", int'(cells_invalid), 0);

        // R6 / R7: hot reset from both sources
        for (int b = 0; b < 2; b++) begin
            ioe_wr = 1'b1; ioe_wdata = 1'b1;
            tick();
            ioe_wr = 1'b0;
            d_i = n_init; d_a = n_abort; w0 = wr_cnt;
            pulse_hot(b != 0);
            repeat (4) tick();
            chk("R6 one reg init", n_init - d_i, 1);
            chk("R6 one core abort", n_abort - d_a, 1);
            chk("R6 enable cleared", int'(int_out), 0);
            chk("R6 ready back", int'(ready), 1);
            chk("R7 no RAM write in hot reset", wr_cnt, w0);
        end

        // R11: hot reset and core-only in the same cycle
        d_i = n_init; d_a = n_abort;
        hot_cmd = 1'b1; core_rst_cmd = 1'b1;
        tick();
        hot_cmd = 1'b0; core_rst_cmd = 1'b0;
        repeat (4) tick();
        chk("R11 reg init count", n_init - d_i, 1);
        chk("R11 abort count", n_abort - d_a, 1);

        // R5: pin low-time sweep across the threshold
        for (int len = 1; len <= PIN_MIN + 2; len++) begin
            d_i = n_init; d_a = n_abort; w0 = wr_cnt;
            rst_pin_n = 1'b0;
            repeat (len) tick();
            rst_pin_n = 1'b1;
            repeat (8) tick();
            chk("R5 reg init vs low time", n_init - d_i, int'(len >= PIN_MIN));
            chk("R5 abort vs low time", n_abort - d_a, int'(len >= PIN_MIN));
            chk("R5 ready after pin", int'(ready), 1);
            chk("R7 no RAM write in warm reset", wr_cnt, w0);
        end
        d_i = n_init;
        rst_pin_n = 1'b0;
        repeat (PIN_MIN + 8) tick();
        chk("R5 default while held", int'(out_default), 1);
        chk("R5 not ready while held", int'(ready), 0);
        rst_pin_n = 1'b1;
        repeat (6) tick();
        chk("R5 released", int'(out_default), 0);
        chk("R5 single init when held", n_init - d_i, 1);

        // R7: hot reset in the middle of the copy cancels it for good
        cold_boot(1);
        for (int k = 0; k < 300 && wr_cnt < 3; k++) tick();
        pulse_hot(1'b0);
        repeat (3) tick();
        w0 = wr_cnt;
        d_a = rd_seen;
        repeat (WAIT + 60) tick();
        chk("R7 copy stopped", wr_cnt, w0);
        chk("R7 partial copy", int'(wr_cnt < WORDS), 1);
        chk("R7 no new reads", rd_seen, d_a);
        chk("R7 ready stays low", int'(ready), 0);

        // R7: warm reset during the start-up wait prevents the copy
        cold_boot(0);
        repeat (3) tick();
        rst_pin_n = 1'b0;
        repeat (PIN_MIN + 1) tick();
        rst_pin_n = 1'b1;
        repeat (WAIT + 60) tick();
        chk("R7 no copy after warm in wait", wr_cnt, 0);
        chk("R7 no reads after warm in wait", rd_seen, 0);
        chk("R7 not ready after warm in wait", int'(ready), 0);

        summary();
    end
endmodule